// File: doc/BRIEF.md
# Up-Counting Timebase with Update Control

This block is a 16-bit up-counting timebase meant to be embedded next to a general-purpose timer. A programmable prescaler divides the clock into counter ticks. The counter climbs from 0 to an active reload value and wraps to 0 on the following tick. The wrap is an overflow, and it can raise an update event. An update event copies the buffered prescale and reload settings into their working copies, raises a one-cycle pulse and may set an interrupt flag.

Software drives the block through a simple synchronous register port: a write strobe, an address and write data, with combinational read data. Control bits select the following:
- whether the counter runs;
- whether update events are suppressed;
- which sources may set the flag;
- whether the counter stops after its next update;
- whether reload writes are buffered.

A software event register forces an update on demand. A two-bit clock-division field is kept for the surrounding logic and has no effect here.

Top module: `tbase_unit`

## Requirements
- R1: After reset every register reads 0, and cnt_o, upd_o, uif_o and irq_o are 0.
- R2: The counter changes only while the run bit (control address 0, bit 0) is 1. It takes one tick every PSC+1 clocks and wraps to 0 on a tick where it equals the active reload value. A write to address 4 loads the counter directly.
- R3: Each update event drives upd_o high for exactly one cycle, in the cycle after the clock edge at which the event occurs.
- R4: With the buffer bit (address 0, bit 7) at 0, a write to the reload register (address 6) takes effect at once. With it at 1, the write is held and becomes active only at an update event. Reads of address 6 return the last value written.
- R5: A write to the prescale register (address 5) is held and becomes active only at an update event. Reads of address 5 return the written value.
- R6: With the suppress bit (address 0, bit 1) at 1, no update event occurs. There is then no upd_o pulse, no flag and no transfer of held values, while the counter still wraps.
- R7: With the source bit (address 0, bit 2) at 0, both overflow and software events set the flag. With it at 1, only overflow sets the flag.
- R8: With the single-shot bit (address 0, bit 3) at 1, an update event clears the run bit, so the counter stops at 0.
- R9: Writing 1 to bit 0 of the event register (address 3) resets the counter and the prescale divider to 0. It also causes an update event, unless that event is suppressed.
- R10: The flag (status address 2, bit 0) is set by a qualifying update event. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R11: irq_o is registered. It equals the flag ANDed with the interrupt enable bit (address 1, bit 0), one cycle later.
- R12: The clock-division field (address 0, bits 9:8) is stored and read back and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on address |
| cnt_o | output | 16 | Current counter value |
| upd_o | output | 1 | One-cycle update event pulse |
| uif_o | output | 1 | Update interrupt flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench uses the default 16-bit width. It sweeps the prescale value from 0 to 2 and the reload value from 0 to 4, with run lengths that cover several wraps. In every combination, the expected count, the number of update pulses and the flag are computed arithmetically. Because the periods are this small, every wrap and every held-value transfer can be reached within a few dozen cycles. Directed sequences then cover suppression, source selection, single-shot stop, buffered and immediate reload, and interrupt timing.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ARR  = 3'd6;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_SUPP = 1;
  localparam int unsigned B_SRC  = 2;
  localparam int unsigned B_ONE  = 3;
  localparam int unsigned B_BUF  = 7;
  localparam int unsigned B_DIV  = 8;
  localparam int unsigned CTRL_W = 10;

  typedef struct packed {
    logic [1:0] div;
    logic       buf_en;
    logic       one_shot;
    logic       src_ovf;
    logic       supp;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tbase_regs.sv
`timescale 1ns/1ps
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     cnt_i,
  input  logic              upd_i,
  input  logic              flag_set_i,
  output logic              run_o,
  output logic              supp_o,
  output logic              src_ovf_o,
  output logic              ie_o,
  output logic              uif_o,
  output logic [DW-1:0]     psc_pre_o,
  output logic [DW-1:0]     arr_pre_o,
  output logic              arr_now_o,
  output logic              ug_o,
  output logic              cnt_ld_o
);
  ctrl_t         ctrl_q, ctrl_d;
  logic          ie_q, uif_q;
  logic [DW-1:0] psc_q, arr_q;
  logic          wr_ctrl, wr_ien, wr_stat, wr_evt, wr_cnt, wr_psc, wr_arr;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_ien  = we_i && (addr_i == A_IEN);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_evt  = we_i && (addr_i == A_EVT);
  assign wr_cnt  = we_i && (addr_i == A_CNT);
  assign wr_psc  = we_i && (addr_i == A_PSC);
  assign wr_arr  = we_i && (addr_i == A_ARR);

  always_comb begin
    ctrl_d.div      = wdata_i[B_DIV +: 2];
    ctrl_d.buf_en   = wdata_i[B_BUF];
    ctrl_d.one_shot = wdata_i[B_ONE];
    ctrl_d.src_ovf  = wdata_i[B_SRC];
    ctrl_d.supp     = wdata_i[B_SUPP];
    ctrl_d.run      = wdata_i[B_RUN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end else if (upd_i && ctrl_q.one_shot) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      uif_q <= 1'b0;
      psc_q <= '0;
      arr_q <= '0;
    end else begin
      if (wr_ien) ie_q <= wdata_i[0];
      // set takes precedence over a software clear in the same cycle
      if (flag_set_i)                  uif_q <= 1'b1;
      else if (wr_stat && !wdata_i[0]) uif_q <= 1'b0;
      if (wr_psc) psc_q <= wdata_i;
      if (wr_arr) arr_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_RUN]      = ctrl_q.run;
        rdata_o[B_SUPP]     = ctrl_q.supp;
        rdata_o[B_SRC]      = ctrl_q.src_ovf;
        rdata_o[B_ONE]      = ctrl_q.one_shot;
        rdata_o[B_BUF]      = ctrl_q.buf_en;
        rdata_o[B_DIV +: 2] = ctrl_q.div;
      end
      A_IEN:  rdata_o[0] = ie_q;
      A_STAT: rdata_o[0] = uif_q;
      A_CNT:  rdata_o    = cnt_i;
      A_PSC:  rdata_o    = psc_q;
      A_ARR:  rdata_o    = arr_q;
      default: rdata_o   = '0;
    endcase
  end

  assign run_o     = ctrl_q.run;
  assign supp_o    = ctrl_q.supp;
  assign src_ovf_o = ctrl_q.src_ovf;
  assign ie_o      = ie_q;
  assign uif_o     = uif_q;
  assign psc_pre_o = psc_q;
  assign arr_pre_o = arr_q;
  assign arr_now_o = wr_arr && !ctrl_q.buf_en;
  assign ug_o      = wr_evt && wdata_i[0];
  assign cnt_ld_o  = wr_cnt;

  a_r8_one_shot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && ctrl_q.one_shot && !wr_ctrl) |=> !ctrl_q.run);
  a_r10_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set_i |=> uif_q);
  a_r10_flag_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_set_i && !wr_stat) |=> $stable(uif_q));
endmodule

// File: rtl/tbase_prescaler.sv
`timescale 1ns/1ps
module tbase_prescaler #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ug_i,
  input  logic          upd_i,
  input  logic [DW-1:0] psc_pre_i,
  output logic          tick_o
);
  logic [DW-1:0] psc_act, div_q;

  assign tick_o = run_i && !ug_i && (div_q == psc_act);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      psc_act <= '0;
    end else begin
      if (ug_i)       div_q <= '0;
      else if (run_i) div_q <= tick_o ? '0 : div_q + 1'b1;
      if (upd_i) psc_act <= psc_pre_i;
    end
  end

  a_r5_div_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= psc_act);
  a_r5_psc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(psc_act));
endmodule

// File: rtl/tbase_counter.sv
`timescale 1ns/1ps
module tbase_counter #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ug_i,
  input  logic          ld_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          arr_now_i,
  input  logic          upd_i,
  input  logic [DW-1:0] arr_pre_i,
  output logic [DW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [DW-1:0] cnt_q, arr_act;

  assign ovf_o = tick_i && (cnt_q == arr_act);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      arr_act <= '0;
    end else begin
      if (ug_i)        cnt_q <= '0;
      else if (ld_i)   cnt_q <= wdata_i;
      else if (tick_i) cnt_q <= ovf_o ? '0 : cnt_q + 1'b1;
      if (arr_now_i)   arr_act <= wdata_i;
      else if (upd_i)  arr_act <= arr_pre_i;
    end
  end

  assign cnt_o = cnt_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ug_i && !ld_i) |=> $stable(cnt_q));
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ug_i && !ld_i) |=> (cnt_q == '0));
  a_r4_reload_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arr_now_i && !upd_i) |=> $stable(arr_act));
endmodule

// File: rtl/tbase_update.sv
`timescale 1ns/1ps
module tbase_update (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic ug_i,
  input  logic supp_i,
  input  logic src_ovf_i,
  output logic upd_o,
  output logic flag_set_o,
  output logic pulse_o
);
  logic pulse_q;

  assign upd_o      = !supp_i && (ovf_i || ug_i);
  assign flag_set_o = upd_o && (ovf_i || !src_ovf_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= upd_o;
  end

  assign pulse_o = pulse_q;

  a_r6_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(!supp_i));
  a_r7_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_set_o && src_ovf_i) |-> ovf_i);
  a_r3_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(ovf_i || ug_i));
endmodule

// File: rtl/tbase_unit.sv
`timescale 1ns/1ps
module tbase_unit
  import tbase_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             uif_o,
  output logic             irq_o
);
  logic             run, supp, src_ovf, ie, uif;
  logic [CNT_W-1:0] psc_pre, arr_pre, cnt;
  logic             arr_now, ug, cnt_ld, tick, ovf, upd, flag_set, pulse;
  logic             irq_q;

  tbase_regs #(.DW(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cnt_i(cnt), .upd_i(upd), .flag_set_i(flag_set),
    .run_o(run), .supp_o(supp), .src_ovf_o(src_ovf), .ie_o(ie), .uif_o(uif),
    .psc_pre_o(psc_pre), .arr_pre_o(arr_pre), .arr_now_o(arr_now),
    .ug_o(ug), .cnt_ld_o(cnt_ld)
  );

  tbase_prescaler #(.DW(CNT_W)) u_psc (
    .clk_i, .rst_ni,
    .run_i(run), .ug_i(ug), .upd_i(upd), .psc_pre_i(psc_pre), .tick_o(tick)
  );

  tbase_counter #(.DW(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i(tick), .ug_i(ug), .ld_i(cnt_ld), .wdata_i(reg_wdata_i),
    .arr_now_i(arr_now), .upd_i(upd), .arr_pre_i(arr_pre),
    .cnt_o(cnt), .ovf_o(ovf)
  );

  tbase_update u_upd (
    .clk_i, .rst_ni,
    .ovf_i(ovf), .ug_i(ug), .supp_i(supp), .src_ovf_i(src_ovf),
    .upd_o(upd), .flag_set_o(flag_set), .pulse_o(pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= uif && ie;
  end

  assign cnt_o = cnt;
  assign upd_o = pulse;
  assign uif_o = uif;
  assign irq_o = irq_q;

  a_r11_irq_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ie));
  a_r11_irq_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(uif));
endmodule

// File: tb/tb_tbase_unit.sv
`timescale 1ns/1ps
module tb_tbase_unit;
  localparam int W = 16;
  localparam logic [2:0] CTRL = 3'd0, IEN = 3'd1, STAT = 3'd2, EVT = 3'd3,
                         CNT = 3'd4, PSC = 3'd5, ARR = 3'd6;
  localparam int RUN = 1, SUPP = 2, SRC = 4, ONE = 8, BUF = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, cnt;
  logic         upd, uif, irq;
  int           n_chk = 0;
  int           n_bad = 0;
  int           ups;
  logic [W-1:0] rv;

  always #10 clk = ~clk;

  tbase_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cnt_o(cnt),
    .upd_o(upd), .uif_o(uif), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = W'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic run(input int n, output int pulses);
    pulses = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (upd) pulses++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cnt", int'(cnt), 0);
    check("R1 upd", int'(upd), 0);
    check("R1 uif", int'(uif), 0);
    check("R1 irq", int'(irq), 0);
    rd(CTRL, rv); check("R1 ctrl", int'(rv), 0);
    rd(ARR, rv);  check("R1 reload", int'(rv), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R10 sweep
    for (int p = 0; p <= 2; p++) begin
      for (int a = 0; a <= 4; a++) begin
        int n, t;
        n = 11 + 2 * p;
        wr(CTRL, SRC);
        wr(PSC, p);
        wr(ARR, a);
        wr(EVT, 1);
        wr(STAT, 0);
        wr(CTRL, SRC | RUN);
        run(n, ups);
        t = n / (p + 1);
        check("R2 count", int'(cnt), t % (a + 1));
        check("R3 pulses", ups, t / (a + 1));
        check("R10 flag", int'(uif), (t / (a + 1)) > 0 ? 1 : 0);
        wr(CTRL, SRC);
      end
    end

    // R2 hold while stopped
    begin
      logic [W-1:0] held;
      held = cnt;
      run(5, ups);
      check("R2 hold", int'(cnt), int'(held));
    end

    // R9 software event, R7 source, R10 clear
    wr(CTRL, 0);
    wr(STAT, 0);
    wr(CNT, 7);
    rd(CNT, rv); check("R2 load", int'(rv), 7);
    wr(EVT, 1);
    check("R9 reinit", int'(cnt), 0);
    check("R9 pulse", int'(upd), 1);
    check("R7 sw sets flag", int'(uif), 1);
    wr(STAT, 1);
    check("R10 write1 keeps", int'(uif), 1);
    wr(STAT, 0);
    check("R10 clear", int'(uif), 0);
    wr(STAT, 1);
    check("R10 write1 no set", int'(uif), 0);
    wr(CTRL, SRC);
    wr(EVT, 1);
    check("R7 sw no flag", int'(uif), 0);

    // R6 suppress
    wr(CTRL, 0);
    wr(PSC, 0);
    wr(ARR, 2);
    wr(EVT, 1);
    wr(STAT, 0);
    wr(CTRL, BUF | SUPP);
    wr(ARR, 5);
    wr(EVT, 1);
    check("R6 no pulse", int'(upd), 0);
    check("R6 no flag", int'(uif), 0);
    wr(CTRL, BUF | SUPP | RUN);
    run(10, ups);
    check("R6 pulses", ups, 0);
    check("R6 wrap old reload", int'(cnt), 10 % 3);
    check("R6 flag", int'(uif), 0);

    // R8 single shot
    wr(CTRL, 0);
    wr(ARR, 3);
    wr(EVT, 1);
    wr(STAT, 0);
    wr(CTRL, ONE | RUN);
    run(10, ups);
    check("R8 pulses", ups, 1);
    check("R8 stopped cnt", int'(cnt), 0);
    rd(CTRL, rv); check("R8 run cleared", int'(rv), ONE);

    // R4 buffered reload
    wr(CTRL, BUF | SRC);
    wr(ARR, 3);
    wr(EVT, 1);
    wr(ARR, 1);
    rd(ARR, rv); check("R4 readback", int'(rv), 1);
    wr(CTRL, BUF | SRC | RUN);
    run(7, ups);
    check("R4 buffered pulses", ups, 2);
    check("R4 buffered cnt", int'(cnt), 1);
    // R4 immediate reload
    wr(CTRL, SRC);
    wr(ARR, 3);
    wr(EVT, 1);
    wr(ARR, 1);
    wr(CTRL, SRC | RUN);
    run(7, ups);
    check("R4 immediate pulses", ups, 3);
    check("R4 immediate cnt", int'(cnt), 1);

    // R5 prescale held until update
    wr(CTRL, SRC);
    wr(ARR, 3);
    wr(EVT, 1);
    wr(PSC, 2);
    rd(PSC, rv); check("R5 readback", int'(rv), 2);
    wr(CTRL, SRC | RUN);
    run(10, ups);
    check("R5 cnt", int'(cnt), 2);
    check("R5 pulses", ups, 1);

    // R11 interrupt timing
    wr(CTRL, 0);
    wr(STAT, 0);
    wr(IEN, 1);
    wr(EVT, 1);
    check("R11 flag", int'(uif), 1);
    check("R11 irq lag", int'(irq), 0);
    @(negedge clk);
    check("R11 irq", int'(irq), 1);
    wr(STAT, 0);
    check("R11 irq lag clear", int'(irq), 1);
    @(negedge clk);
    check("R11 irq clear", int'(irq), 0);
    wr(IEN, 0);
    wr(EVT, 1);
    @(negedge clk);
    @(negedge clk);
    check("R11 masked", int'(irq), 0);

    // R12 division field stored only
    wr(CTRL, (2 << 8) | SRC);
    rd(CTRL, rv); check("R12 readback", int'(rv), 512 + SRC);
    wr(PSC, 0);
    wr(ARR, 4);
    wr(EVT, 1);
    wr(CTRL, (3 << 8) | SRC | RUN);
    run(7, ups);
    check("R12 no effect cnt", int'(cnt), 7 % 5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule